// File: doc/BRIEF.md
# Live-Tracking Segmented Memory with Per-Segment Sleep

This block is a small on-chip data store split into equal segments. Each segment keeps one flag per word that records whether the word holds a value still waiting to be consumed. A write marks its word as holding a value. A read issued with the `rd_last` qualifier is the final use of that value, so it clears the flag. An ordinary read leaves the flag set.

A segment whose flags are all clear has nothing worth keeping. It drops its clock enable and reports itself asleep. It wakes in the same cycle that a write is aimed at it. Whether a segment is idle depends only on the data it holds, not on how often it is accessed. A segment that holds one value and is never read stays awake.

The scheduler that produces the access stream places variables with overlapping lifetimes in the same segment, and the block relies on that placement. Each segment also keeps a saturating count of the clock cycles it has spent asleep.

Top module: `seg_sleep_mem`

## Requirements
- R1: The address splits into a segment index and a word index. The segment index is the upper `$clog2(SEG_COUNT)` bits and the word index is the lower `$clog2(SEG_WORDS)` bits. With the defaults, address 5'b10_011 is word 3 of segment 2.
- R2: While `rst` is high, and after it is released, all live flags are clear, every `seg_asleep` bit is 1, every `seg_clk_en` bit is 0, every sleep counter is 0 and `rd_valid` is 0.
- R3: A write stores `wr_data` and marks its word live. The result of a read accepted at clock edge N appears on `rd_valid`, `rd_err` and `rd_data` after edge N. For a live word, `rd_valid`=1, `rd_err`=0 and `rd_data` holds the stored word. When no read was accepted, `rd_valid` and `rd_err` are 0 and `rd_data` is 0.
- R4: A read with `rd_last`=0 leaves the word live. A read with `rd_last`=1 on a live word returns its data and clears its live flag.
- R5: A segment's `seg_asleep` rises in the cycle after the edge at which its last live word is released. A segment holding at least one live word stays awake, whether or not it is accessed.
- R6: A write aimed at an asleep segment drives its `seg_asleep` low and its `seg_clk_en` high in the same cycle, combinationally, and the write completes at that edge.
- R7: A read of a word that is not live, including any word of an asleep segment, returns `rd_err`=1 and `rd_data`=0 and changes no state.
- R8: Each segment's sleep counter increments at every clock edge at which that segment was asleep and saturates at 2^CNT_W-1. It clears only on reset.
- R9: When a write and a last-use read hit the same word in one cycle, the write wins. The word stays live with the new data, and the read returns the value and status from before that edge.
- R10: Segments are independent. An access to one segment never changes another segment's live flags, sleep state or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address (segment, word) |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address (segment, word) |
| rd_last | input | 1 | Read is the final use of the value |
| rd_valid | output | 1 | Read result present |
| rd_err | output | 1 | Read hit a non-live word or an asleep segment |
| rd_data | output | DATA_W | Read data, zero when invalid or in error |
| seg_asleep | output | SEG_COUNT | Per-segment sleep status |
| seg_clk_en | output | SEG_COUNT | Per-segment clock enable |
| sleep_cycles | output | SEG_COUNT*CNT_W | Packed per-segment asleep-cycle counters, segment s in bits [s*CNT_W +: CNT_W] |

## Verification
The hardest cases to reach are a write and a last-use read striking the same word at one edge, and a segment going back to sleep while a neighbour stays busy. Reaching either needs several segments holding values at once, followed by a precise release order.

Directed phases build these situations on purpose. A long random phase then confines addresses to a few words per segment and issues last-use reads often. This drives segments through many sleep and wake cycles, with collisions between reads and writes. A behavioural model in the bench predicts every output on every cycle, including the counters once they have saturated.

// File: rtl/segmem_pkg.sv
package segmem_pkg;

  // Power state of one segment
  typedef enum logic {
    SEG_AWAKE  = 1'b0,
    SEG_ASLEEP = 1'b1
  } seg_pwr_e;

endpackage

// File: rtl/segmem_sleep_ctr.sv
module segmem_sleep_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (count_en && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;

  // R8: a full counter stays full
  a_r8_saturates: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R8: no counting while awake
  a_r8_holds_awake: assert property (@(posedge clk) disable iff (rst)
    !count_en |=> $stable(cnt_q));

endmodule

// File: rtl/segmem_segment.sv
module segmem_segment
  import segmem_pkg::*;
#(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_hit,
  input  logic [$clog2(WORDS)-1:0] wr_word,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_hit,
  input  logic [$clog2(WORDS)-1:0] rd_word,
  input  logic                     rd_last,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_err_o,
  output logic                     asleep_o,
  output logic                     clk_en_o,
  output logic [CNT_W-1:0]         sleep_cnt_o
);

  localparam int unsigned CW = $clog2(WORDS + 1);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rdata_q;
  logic [WORDS-1:0]  live_q, live_d;
  logic [CW-1:0]     lcnt_q, lcnt_d;
  seg_pwr_e          state_q, state_d;
  logic              rd_err_now, rd_err_q;
  logic              release_hit, set_new, drop_one;

  // Error when the segment sleeps or the word holds nothing
  assign rd_err_now  = (state_q == SEG_ASLEEP) || !live_q[rd_word];
  assign release_hit = rd_hit && rd_last && !rd_err_now;
  assign set_new     = wr_hit && !live_q[wr_word];
  assign drop_one    = release_hit && !(wr_hit && (wr_word == rd_word));

  always_comb begin
    live_d = live_q;
    if (release_hit) live_d[rd_word] = 1'b0;
    if (wr_hit)      live_d[wr_word] = 1'b1;  // write wins on collision
  end

  always_comb begin
    lcnt_d = lcnt_q + {{(CW-1){1'b0}}, set_new} - {{(CW-1){1'b0}}, drop_one};
    state_d = (lcnt_d == '0) ? SEG_ASLEEP : SEG_AWAKE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      lcnt_q   <= '0;
      state_q  <= SEG_ASLEEP;
      rd_err_q <= 1'b0;
    end else begin
      live_q   <= live_d;
      lcnt_q   <= lcnt_d;
      state_q  <= state_d;
      rd_err_q <= rd_hit && rd_err_now;
    end
  end

  // Block-RAM style storage: one write port, registered read-before-write
  always_ff @(posedge clk) begin
    if (wr_hit) mem[wr_word] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_hit) rdata_q <= mem[rd_word];
  end

  assign rd_data_o = rdata_q;
  assign rd_err_o  = rd_err_q;
  assign asleep_o  = (state_q == SEG_ASLEEP) && !wr_hit;
  assign clk_en_o  = !asleep_o;

  segmem_sleep_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .count_en (state_q == SEG_ASLEEP),
    .count_o  (sleep_cnt_o)
  );

  // R5: the live count agrees with the live flags
  a_r5_count_matches: assert property (@(posedge clk) disable iff (rst)
    int'(lcnt_q) == $countones(live_q));

  // R5: a sleeping segment holds no live word
  a_r5_sleep_empty: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEG_ASLEEP) |-> (live_q == '0));

  // R6: a write leaves the segment awake after the edge
  a_r6_awake_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (state_q == SEG_AWAKE));

  // R4: a last-use read without a colliding write frees its word
  a_r4_last_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && rd_last && !rd_err_now && !(wr_hit && wr_word == rd_word))
      |=> !live_q[$past(rd_word)]);

  // R7: an erroring read changes no live flag
  a_r7_err_no_change: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && rd_err_now && !wr_hit) |=> $stable(live_q));

endmodule

// File: rtl/seg_sleep_mem.sv
module seg_sleep_mem
  import segmem_pkg::*;
#(
  parameter int unsigned SEG_COUNT = 4,
  parameter int unsigned SEG_WORDS = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CNT_W     = 8,
  localparam int unsigned SEG_W    = $clog2(SEG_COUNT),
  localparam int unsigned WORD_W   = $clog2(SEG_WORDS),
  localparam int unsigned ADDR_W   = SEG_W + WORD_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic                       rd_last,
  output logic                       rd_valid,
  output logic                       rd_err,
  output logic [DATA_W-1:0]          rd_data,
  output logic [SEG_COUNT-1:0]       seg_asleep,
  output logic [SEG_COUNT-1:0]       seg_clk_en,
  output logic [SEG_COUNT*CNT_W-1:0] sleep_cycles
);

  logic [SEG_W-1:0]  wr_seg, rd_seg, rd_seg_q;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic              rd_valid_q;
  logic [DATA_W-1:0] seg_rdata [SEG_COUNT];
  logic [SEG_COUNT-1:0] seg_err;

  // Segment index from the upper bits, word index from the lower bits
  assign wr_seg  = wr_addr[ADDR_W-1 -: SEG_W];
  assign wr_word = wr_addr[WORD_W-1:0];
  assign rd_seg  = rd_addr[ADDR_W-1 -: SEG_W];
  assign rd_word = rd_addr[WORD_W-1:0];

  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
    segmem_segment #(
      .WORDS  (SEG_WORDS),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
    ) u_seg (
      .clk         (clk),
      .rst         (rst),
      .wr_hit      (wr_en && (wr_seg == SEG_W'(s))),
      .wr_word     (wr_word),
      .wr_data     (wr_data),
      .rd_hit      (rd_en && (rd_seg == SEG_W'(s))),
      .rd_word     (rd_word),
      .rd_last     (rd_last),
      .rd_data_o   (seg_rdata[s]),
      .rd_err_o    (seg_err[s]),
      .asleep_o    (seg_asleep[s]),
      .clk_en_o    (seg_clk_en[s]),
      .sleep_cnt_o (sleep_cycles[s*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_seg_q   <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rd_seg_q   <= rd_seg;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_err   = rd_valid_q && seg_err[rd_seg_q];
  assign rd_data  = (rd_valid_q && !seg_err[rd_seg_q]) ? seg_rdata[rd_seg_q] : '0;

  // R3: every accepted read yields a result one edge later
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R6: a targeted segment is never reported asleep
  a_r6_write_wakes: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !seg_asleep[wr_seg]);

  // R10: a write can wake at most one segment
  a_r10_one_woken: assert property (@(posedge clk) disable iff (rst)
    $onehot0(seg_clk_en & ~$past(seg_clk_en) & ~(rd_en ? '0 : '0)));

endmodule

// File: tb/seg_sleep_mem_test.sv
`timescale 1ns/1ps
module seg_sleep_mem_test;

  localparam int SEGS  = 4;
  localparam int WORDS = 8;
  localparam int DW    = 16;
  localparam int CW    = 8;
  localparam int AW    = 5;
  localparam int CMAX  = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, rd_last = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic rd_valid, rd_err;
  logic [DW-1:0] rd_data;
  logic [SEGS-1:0] seg_asleep, seg_clk_en;
  logic [SEGS*CW-1:0] sleep_cycles;

  always #2.5 clk = ~clk;

  seg_sleep_mem uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_last(rd_last),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
    .seg_asleep(seg_asleep), .seg_clk_en(seg_clk_en),
    .sleep_cycles(sleep_cycles)
  );

  // Behavioural reference state
  int  mem_m  [SEGS*WORDS];
  bit  live_m [SEGS*WORDS];
  bit  sleep_m[SEGS];
  int  cnt_m  [SEGS];
  bit  exp_valid, exp_err;
  int  exp_data;
  int  checks = 0, errors = 0;
  bit  done = 0;
  string req = "R2";

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic bit seg_live(input int s);
    for (int w = 0; w < WORDS; w++) if (live_m[s*WORDS+w]) return 1;
    return 0;
  endfunction

  // One clock cycle: check registered outputs, drive, check wake path, advance model
  task automatic step(input bit we, input int wa, input int wd,
                      input bit re, input int ra, input bit rl);
    chk(rd_valid == exp_valid, req, rd_valid, exp_valid);
    chk(rd_err == exp_err, req, rd_err, exp_err);
    chk(int'(rd_data) == exp_data, req, rd_data, exp_data);
    for (int s = 0; s < SEGS; s++)
      chk(int'(sleep_cycles[s*CW +: CW]) == cnt_m[s], {req, "/R8"},
          sleep_cycles[s*CW +: CW], cnt_m[s]);
    wr_en = we; wr_addr = AW'(wa); wr_data = DW'(wd);
    rd_en = re; rd_addr = AW'(ra); rd_last = rl;
    #1;
    for (int s = 0; s < SEGS; s++) begin
      bit e = sleep_m[s] && !(we && (wa / WORDS) == s);
      chk(seg_asleep[s] == e, {req, "/R6"}, seg_asleep[s], e);
      chk(seg_clk_en[s] == !e, {req, "/R6"}, seg_clk_en[s], !e);
    end
    @(posedge clk);
    for (int s = 0; s < SEGS; s++)
      if (sleep_m[s] && cnt_m[s] < CMAX) cnt_m[s]++;
    exp_valid = re; exp_err = 0; exp_data = 0;
    if (re) begin
      if (!live_m[ra]) exp_err = 1;
      else begin
        exp_data = mem_m[ra];
        if (rl) live_m[ra] = 0;
      end
    end
    if (we) begin mem_m[wa] = wd; live_m[wa] = 1; end
    for (int s = 0; s < SEGS; s++) sleep_m[s] = !seg_live(s);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SEGS*WORDS; i++) begin mem_m[i] = 0; live_m[i] = 0; end
    for (int s = 0; s < SEGS; s++) begin sleep_m[s] = 1; cnt_m[s] = 0; end
    exp_valid = 0; exp_err = 0; exp_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: state during reset
    chk(seg_asleep == '1, "R2", seg_asleep, 15);
    chk(seg_clk_en == '0, "R2", seg_clk_en, 0);
    chk(sleep_cycles == '0, "R2", 0, 0);
    chk(rd_valid == 0, "R2", rd_valid, 0);
    rst = 0;
    req = "R2"; idle(3);
    // R8: saturation while all segments sleep
    req = "R8"; idle(300);
    // R1/R6: word 3 of segment 2 (address 5'b10_011)
    req = "R1"; step(1, 5'b10011, 16'hA5C3, 0, 0, 0);
    chk(seg_asleep == 4'b1011, "R1", seg_asleep, 11);
    // R3: read back, ordinary read keeps word live
    req = "R3"; step(0, 0, 0, 1, 19, 0);
    req = "R4"; step(0, 0, 0, 1, 19, 0);
    // R4/R5: last use releases, segment sleeps next cycle
    req = "R5"; step(0, 0, 0, 1, 19, 1);
    idle(2);
    // R7: read of freed word and of an asleep segment
    req = "R7"; step(0, 0, 0, 1, 19, 0);
    step(0, 0, 0, 1, 7, 1);
    idle(1);
    // R10: two segments live, release one, the other stays awake
    req = "R10"; step(1, 1, 111, 0, 0, 0);
    step(1, 25, 222, 0, 0, 0);
    step(1, 26, 333, 1, 1, 1);
    idle(5);
    step(0, 0, 0, 1, 25, 1);
    step(0, 0, 0, 1, 26, 1);
    idle(2);
    // R9: write and last-use read of the same word together
    req = "R9"; step(1, 12, 500, 0, 0, 0);
    step(1, 12, 600, 1, 12, 1);
    step(0, 0, 0, 1, 12, 1);
    idle(2);
    // R5: many live words in one segment, released one by one
    req = "R5";
    for (int w = 0; w < WORDS; w++) step(1, 8 + w, 1000 + w, 0, 0, 0);
    idle(4);
    for (int w = 0; w < WORDS; w++) step(0, 0, 0, 1, 8 + w, 1);
    idle(3);
    // Mixed traffic
    req = "R3";
    for (int i = 0; i < 3000; i++) begin
      int wa = $urandom_range(0, SEGS-1) * WORDS + $urandom_range(0, 2);
      int ra = $urandom_range(0, SEGS-1) * WORDS + $urandom_range(0, 2);
      step($urandom_range(0, 3) == 0, wa, $urandom_range(0, 65535),
           $urandom_range(0, 1) == 1, ra, $urandom_range(0, 2) != 0);
    end
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule